// File: doc/BRIEF.md
# Prescaled Watchdog Reset Timer

A watchdog for a small microcontroller. A wide up-counter advances on ticks from a programmable clock divider while it is enabled. If software does not restart it in time, the counter wraps from all-ones to zero and the block drives a fixed-length reset request into the chip's reset tree.

Software controls the block through a single 8-bit control register. The register is written when the address-match input and the write strobe are both high. The register holds an enable bit and a 3-bit divider select. A write-one strobe bit in the same register zeroes the count and restarts the time base. The current enable and divider select can always be read back. The counter width and the reset-request length are parameters; the defaults are 16 bits and 4 cycles.

Top module: `wdog_timer`

## Requirements
- R1: While rst_ni is low and after it is released, the control register reads 0x00 (enable off, divider select 000) and wdt_rst_o is low. An external reset during counting cancels any pending timeout.
- R2: The read value places the enable at bit 7 and the divider select at bits 2:0. Bits 6, 4 and 3 ignore writes and read 0. Bit 5 (clear strobe) always reads 0.
- R3: While the enable is 0, the counter keeps its value and the divider is held at zero. After re-enabling, counting resumes from the held value.
- R4: With divider select PS, the counter advances once every 2^(PS+1) clock cycles. After a write that enables the block at clock edge E, wdt_rst_o rises at edge E + 2^(CNT_W+PS+1), unless the counter is cleared or disabled first.
- R5: On overflow, wdt_rst_o is high for exactly PULSE_CYC (default 4) consecutive cycles and then falls. It rises only after an overflow.
- R6: A watchdog overflow clears the enable and the counter. The divider select keeps its value.
- R7: Writing 1 to bit 5 zeroes the counter and the divider. The next timeout is a full period, measured from that write's edge.
- R8: If a clear write and an overflow occur in the same cycle, the clear wins and no reset request is raised.
- R9: Writes are ignored while wdt_rst_o is high. A write without the clear bit in the overflow cycle is also ignored.
- R10: A write takes effect only when sel_i and we_i are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous hardware reset |
| sel_i | input | 1 | Address match for the control register |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Control register read value |
| wdt_rst_o | output | 1 | Chip reset request, high for PULSE_CYC cycles |

## Verification
Some properties are checked by assertions on every cycle:
- the reserved bits read as zero;
- the enable is off while a reset request is active;
- the divider select does not change at a watchdog reset;
- the request rises only after an overflow;
- a clear zeroes the count and suppresses a same-cycle overflow;
- the count holds between ticks.

Other properties can only be shown by the bench's scenarios. These are the exact timeout edge for each divider setting, the 4-cycle pulse width, the resumption of counting after a pause, and the rejection of writes in the overflow cycle and during the pulse. The bench uses a narrow counter so that full periods fit in the run.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned PS_W   = 3;
  localparam int unsigned EN_BIT = 7;
  localparam int unsigned CLR_BIT = 5;

  typedef struct packed {
    logic            en;
    logic [PS_W-1:0] ps;
  } wdog_ctrl_t;
endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
  import wdog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             ovf_i,
  input  logic             pulse_i,
  output wdog_ctrl_t       ctrl_o,
  output logic             clr_o,
  output logic [REG_W-1:0] rdata_o
);
  wdog_ctrl_t ctrl_q;
  logic       wr_ok;
  logic       unused_rsvd;

  assign unused_rsvd = ^{wdata_i[6], wdata_i[4:3]};
  assign wr_ok  = wr_i && !pulse_i;
  assign clr_o  = wr_ok && wdata_i[CLR_BIT];
  assign ctrl_o = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ovf_i || pulse_i) begin
      ctrl_q.en <= 1'b0;  // divider select survives a watchdog reset
    end else if (wr_ok) begin
      ctrl_q.en <= wdata_i[EN_BIT];
      ctrl_q.ps <= wdata_i[PS_W-1:0];
    end
  end

  always_comb begin
    rdata_o             = '0;
    rdata_o[EN_BIT]     = ctrl_q.en;
    rdata_o[PS_W-1:0]   = ctrl_q.ps;
  end

  // R9: no register change while the reset request is active
  a_r9_locked_in_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |=> $stable(ctrl_q.ps) && !ctrl_q.en);
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned PS_W = 3,
  localparam int unsigned PRE_W = 2 ** PS_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            clr_i,
  input  logic [PS_W-1:0] ps_i,
  output logic            tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   mask_w;
  logic [PRE_W-1:0] mask;

  // divide by 2^(ps+1): tick when the low ps+1 bits are all ones
  assign mask_w = ({{PRE_W{1'b0}}, 1'b1} << ({1'b0, ps_i} + 1'b1)) - 1'b1;
  assign mask   = mask_w[PRE_W-1:0];
  assign tick_o = en_i && ((pre_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pre_q <= '0;
    else if (!en_i || clr_i)  pre_q <= '0;
    else                      pre_q <= pre_q + 1'b1;
  end

  // R7: a clear restarts the divider, so no tick the next cycle
  a_r7_clr_restarts_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !tick_o);
  // R3: divider stays parked while disabled
  a_r3_div_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> pre_q == '0);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  input  logic hold_i,
  output logic ovf_o
);
  logic [CNT_W-1:0] cnt_q;

  // clear wins over a simultaneous wrap
  assign ovf_o = tick_i && (&cnt_q) && !clr_i && !hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || hold_i)  cnt_q <= '0;
    else if (tick_i)           cnt_q <= cnt_q + 1'b1;
  end

  a_r7_clear_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
  a_r3_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !clr_i && !hold_i |=> $stable(cnt_q));
  a_r6_zero_after_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> cnt_q == '0);
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int unsigned PULSE_CYC = 4,
  localparam int unsigned PW = $clog2(PULSE_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_i,
  output logic rst_o
);
  logic [PW-1:0] left_q;

  assign rst_o = left_q != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      left_q <= '0;
    else if (ovf_i)   left_q <= PW'(PULSE_CYC);
    else if (rst_o)   left_q <= left_q - 1'b1;
  end

  a_r5_rise_needs_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_o) |-> $past(ovf_i));
  a_r5_ovf_starts_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> rst_o);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned PULSE_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             wdt_rst_o
);
  wdog_ctrl_t ctrl;
  logic       clr, tick, ovf, wr;

  assign wr = sel_i && we_i;

  wdog_ctrl_reg u_ctrl (
    .clk_i, .rst_ni, .wr_i(wr), .wdata_i, .ovf_i(ovf), .pulse_i(wdt_rst_o),
    .ctrl_o(ctrl), .clr_o(clr), .rdata_o
  );

  wdog_prescaler #(.PS_W(PS_W)) u_div (
    .clk_i, .rst_ni, .en_i(ctrl.en), .clr_i(clr), .ps_i(ctrl.ps), .tick_o(tick)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .clr_i(clr), .hold_i(wdt_rst_o), .ovf_o(ovf)
  );

  wdog_pulse #(.PULSE_CYC(PULSE_CYC)) u_pls (
    .clk_i, .rst_ni, .ovf_i(ovf), .rst_o(wdt_rst_o)
  );

  a_r2_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[6:3] == 4'b0);
  a_r6_en_off_in_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> !rdata_o[EN_BIT]);
  a_r6_ps_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_o) |-> $stable(rdata_o[PS_W-1:0]));
  a_r8_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && wdata_i[CLR_BIT] && !wdt_rst_o |=> !$rose(wdt_rst_o));
  a_r10_no_write_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr && !ovf && !wdt_rst_o |=> $stable(rdata_o));
endmodule

// File: tb/sim_wdog_timer.sv
module sim_wdog_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 6;
  localparam int PLEN = 4;

  logic       clk = 0, rst_ni = 0, sel = 0, we = 0;
  logic [7:0] wdata = '0, rdata;
  logic       wdt_rst;
  int         cyc = 0, n_run = 0, n_fail = 0;
  int         exp_q[$];

  wdog_timer #(.CNT_W(CW), .PULSE_CYC(PLEN)) u0 (
    .clk_i(clk), .rst_ni, .sel_i(sel), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .wdt_rst_o(wdt_rst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int period(input int ps);
    return 1 << (CW + ps + 1);
  endfunction

  // drive one write for the next edge; returns that edge number
  task automatic wr(input logic [7:0] d, input logic s, input logic w, output int e);
    sel = s; we = w; wdata = d; e = cyc + 1;
    @(posedge clk); @(negedge clk);
    sel = 0; we = 0; wdata = '0;
  endtask

  task automatic to_edge(input int target);
    while (cyc + 1 < target) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0 || wdt_rst) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pops expected rise edges, checks pulse width
  logic prev_rst = 0;
  int   width = 0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (wdt_rst && !prev_rst) begin
        if (exp_q.size() == 0) chk(0, "R5/R8/R9 unexpected reset request", cyc, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(cyc == e, "R4 timeout edge", cyc, e);
        end
        width = 1;
      end else if (wdt_rst) width++;
      else if (prev_rst) chk(width == PLEN, "R5 pulse width", width, PLEN);
    end
    prev_rst = rst_ni && wdt_rst;
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog timeout", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int e, e2;
    repeat (3) @(negedge clk);
    chk(rdata == 8'h00, "R1 reset value", rdata, 8'h00);
    chk(wdt_rst == 0, "R1 no request in reset", wdt_rst, 0);
    rst_ni = 1;
    @(negedge clk);

    // R2: reserved and strobe bits read 0
    wr(8'h7B, 1, 1, e);
    chk(rdata == 8'h03, "R2 reserved ignored", rdata, 8'h03);
    // R10: needs sel and we
    wr(8'h84, 0, 1, e);
    chk(rdata == 8'h03, "R10 no sel", rdata, 8'h03);
    wr(8'h84, 1, 0, e);
    chk(rdata == 8'h03, "R10 no we", rdata, 8'h03);

    // R4/R6: ps=2 timeout, then enable off, ps kept
    wr(8'hFA, 1, 1, e);
    chk(rdata == 8'h82, "R2 read format", rdata, 8'h82);
    exp_q.push_back(e + period(2));
    wait_idle();
    chk(rdata == 8'h02, "R6 enable cleared ps kept", rdata, 8'h02);

    // R9: write during pulse ignored
    wr(8'h80, 1, 1, e);
    exp_q.push_back(e + period(0));
    while (!wdt_rst) @(negedge clk);
    wr(8'h87, 1, 1, e2);
    wait_idle();
    chk(rdata == 8'h00, "R9 write in pulse ignored", rdata, 8'h00);

    // R7: clear restarts full period
    wr(8'h81, 1, 1, e);
    repeat (200) @(negedge clk);
    wr(8'hA1, 1, 1, e2);
    exp_q.push_back(e2 + period(1));
    wait_idle();
    chk(rdata == 8'h01, "R7 after cleared timeout", rdata, 8'h01);

    // R3: pause holds count
    wr(8'h80, 1, 1, e);
    to_edge(e + 40);
    wr(8'h00, 1, 1, e2);
    repeat (300) @(negedge clk);
    chk(wdt_rst == 0, "R3 no timeout while disabled", wdt_rst, 0);
    wr(8'h80, 1, 1, e);
    exp_q.push_back(e + ((1 << CW) - 20) * 2);
    wait_idle();

    // R8: clear in overflow cycle wins
    wr(8'h80, 1, 1, e);
    to_edge(e + period(0));
    wr(8'hA0, 1, 1, e2);
    exp_q.push_back(e2 + period(0));
    chk(wdt_rst == 0, "R8 clear beats overflow", wdt_rst, 0);
    wait_idle();

    // R9: non-clear write in overflow cycle ignored
    wr(8'h80, 1, 1, e);
    exp_q.push_back(e + period(0));
    to_edge(e + period(0));
    wr(8'h87, 1, 1, e2);
    wait_idle();
    chk(rdata == 8'h00, "R9 overflow-cycle write ignored", rdata, 8'h00);

    // R4: slowest divider
    wr(8'h87, 1, 1, e);
    exp_q.push_back(e + period(7));
    wait_idle();
    chk(rdata == 8'h07, "R6 ps kept after ps7 timeout", rdata, 8'h07);

    // R1: external reset cancels pending timeout
    wr(8'h80, 1, 1, e);
    repeat (50) @(negedge clk);
    rst_ni = 0;
    @(negedge clk);
    chk(rdata == 8'h00, "R1 reset clears register", rdata, 8'h00);
    rst_ni = 1;
    repeat (300) @(negedge clk);
    chk(wdt_rst == 0, "R1 pending timeout cancelled", wdt_rst, 0);
    chk(exp_q.size() == 0, "R4 all timeouts seen", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule